// File: doc/BRIEF.md
# Carrier Frequency Window Detector

This block decides whether a valid carrier is present on a received line. It sits after two analog threshold comparators and receives their digital flags. One flag means the signal is above the upper threshold, and the other means it is below the lower threshold. The flags are synchronized to the local clock. A hysteresis latch then turns them into a clean square wave, which rejects small-amplitude noise that never crosses both thresholds.

The block times each square-wave period, in local clocks, from one rising edge to the next. A period qualifies only when it is close to one sixteenth of the clock frequency: between 15 and 17 clocks, or roughly 236 to 266 kHz from a 4 MHz clock. A run-length qualifier then drives an active-low detect output. It asserts the output only after a parameterized number of qualifying periods in a row. It releases the output only after the same number of non-qualifying or missing periods in a row. With the default count of 10 and a 250 kHz carrier, both acquiring and losing the carrier take about 40 to 46 us.

Top module: `carrier_window_det`

## Requirements
- R1: While reset is asserted, and right after reset is released, `det_n` is 1 (no carrier) and `sq_out` is 1.
- R2: `sq_out` becomes 0 when only `cmp_hi` is 1 and becomes 1 when only `cmp_lo` is 1. When both flags are 0, or both are 1, `sq_out` keeps its value. A change on the flags reaches `sq_out` on the third rising clock edge, because of the two synchronizer stages and the latch.
- R3: A period is the number of clocks between two successive rising edges of the shaped wave. A period qualifies when it is 15, 16 or 17 clocks.
- R4: A square wave with a steady period shorter than 15 clocks or longer than 17 clocks never asserts `det_n`, however long it lasts.
- R5: If 18 clocks pass after a rising edge with no new rising edge, a non-qualifying period is recorded. The next rising edge then only starts a new measurement and gives no verdict. The first rising edge after reset also gives no verdict.
- R6: `det_n` falls to 0 on the clock edge that registers the CONFIRM-th qualifying period in a row (default 10). From idle, a steady in-window wave therefore asserts `det_n` on its CONFIRM+1-th rising edge, and not on its CONFIRM-th.
- R7: While `det_n` is 0, it returns to 1 after CONFIRM non-qualifying periods in a row. Both out-of-window periods and timeouts count. If the line stops toggling, `det_n` rises 21 + 18*(CONFIRM-1) clock edges after the edge that first sampled the last low-going phase start: 183 edges with the defaults.
- R8: A period of the opposite kind clears the run count in both directions. An acquisition that is interrupted needs a full new run of CONFIRM qualifying periods, and a loss that is interrupted needs a full new run of CONFIRM non-qualifying periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, sixteen times the nominal carrier frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 1 | Comparator flag: signal above the upper threshold |
| cmp_lo | input | 1 | Comparator flag: signal below the lower threshold |
| sq_out | output | 1 | Shaped square wave from the hysteresis latch |
| det_n | output | 1 | Carrier present, active low |

## Verification
A corrupted period counter or armed flag shows up as a shifted acquisition point. With a steady in-window wave, `det_n` then falls one edge early or late, or never falls. So the bench checks the exact rising edge on which it falls: after the CONFIRM+1-th edge and not after the CONFIRM-th. A run counter that is not cleared by a period of the opposite kind makes `det_n` toggle one period early after an interruption, which the interrupted-run sequences expose within a single carrier period. A timeout counter that is off by one moves the silent-line release by about one clock per missing period. That error is caught by checking `det_n` on both sides of the computed release edge.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

    localparam int unsigned CDET_MIN_PER = 15;
    localparam int unsigned CDET_MAX_PER = 17;
    localparam int unsigned CDET_TMO     = 18;
    localparam int unsigned CDET_CONFIRM = 10;
    localparam int unsigned CDET_SYNC    = 2;

    typedef enum logic [1:0] {
        VERD_NONE = 2'b00,
        VERD_GOOD = 2'b01,
        VERD_BAD  = 2'b10
    } verdict_e;

endpackage

// File: rtl/cdet_sync.sv
module cdet_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.stg[STAGES-1];

endmodule

// File: rtl/cdet_shaper.sv
module cdet_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output logic sq
);

    typedef struct packed {
        logic sq;
    } shp_t;

    shp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (above_hi && !below_lo)      st_d.sq = 1'b0;
        else if (below_lo && !above_hi) st_d.sq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sq: 1'b1};
        else        st_q <= st_d;
    end

    assign sq = st_q.sq;

endmodule

// File: rtl/cdet_period.sv
module cdet_period
    import cdet_pkg::*;
#(
    parameter int unsigned MIN_PER  = CDET_MIN_PER,
    parameter int unsigned MAX_PER  = CDET_MAX_PER,
    parameter int unsigned TMO_CLKS = CDET_TMO
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sq,
    output verdict_e verdict
);

    localparam int unsigned CNT_W = $clog2(TMO_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_PER);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PER);
    localparam logic [CNT_W-1:0] CNT_TMO = CNT_W'(TMO_CLKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev;
        logic             armed;
    } per_t;

    per_t     st_d, st_q;
    logic     rise;
    logic     in_win;
    verdict_e verd_d;

    always_comb begin
        st_d    = st_q;
        verd_d  = VERD_NONE;
        rise    = sq && !st_q.prev;
        in_win  = (st_q.cnt >= CNT_MIN) && (st_q.cnt <= CNT_MAX);
        st_d.prev = sq;
        if (rise) begin
            if (st_q.armed) verd_d = in_win ? VERD_GOOD : VERD_BAD;
            st_d.cnt   = CNT_ONE;
            st_d.armed = 1'b1;
        end else if (st_q.cnt >= CNT_TMO) begin
            verd_d     = VERD_BAD;
            st_d.cnt   = CNT_ONE;
            st_d.armed = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: CNT_ONE, prev: 1'b1, armed: 1'b0};
        else        st_q <= st_d;
    end

    assign verdict = verd_d;

endmodule

// File: rtl/cdet_qualify.sv
module cdet_qualify
    import cdet_pkg::*;
#(
    parameter int unsigned CONFIRM = CDET_CONFIRM
) (
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_e verdict,
    output logic     det
);

    localparam int unsigned RUN_W = $clog2(CONFIRM + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(CONFIRM - 1);

    typedef struct packed {
        logic             det;
        logic [RUN_W-1:0] run;
    } qual_t;

    qual_t st_d, st_q;
    logic  toward;
    logic  against;

    always_comb begin
        st_d    = st_q;
        toward  = st_q.det ? (verdict == VERD_BAD)  : (verdict == VERD_GOOD);
        against = st_q.det ? (verdict == VERD_GOOD) : (verdict == VERD_BAD);
        if (toward) begin
            if (st_q.run == RUN_LAST) begin
                st_d.det = !st_q.det;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + RUN_W'(1);
            end
        end else if (against) begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{det: 1'b0, run: '0};
        else        st_q <= st_d;
    end

    assign det = st_q.det;

endmodule

// File: rtl/carrier_window_det.sv
module carrier_window_det
    import cdet_pkg::*;
#(
    parameter int unsigned MIN_PER     = CDET_MIN_PER,
    parameter int unsigned MAX_PER     = CDET_MAX_PER,
    parameter int unsigned TMO_CLKS    = CDET_TMO,
    parameter int unsigned CONFIRM     = CDET_CONFIRM,
    parameter int unsigned SYNC_STAGES = CDET_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_hi,
    input  logic cmp_lo,
    output logic sq_out,
    output logic det_n
);

    logic [1:0] flags_s;
    logic       sq_w;
    logic       det_w;
    verdict_e   verd_w;
    logic       cyc_good;
    logic       cyc_bad;

    cdet_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp_hi, cmp_lo}),
        .q     (flags_s)
    );

    cdet_shaper u_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .above_hi (flags_s[1]),
        .below_lo (flags_s[0]),
        .sq       (sq_w)
    );

    cdet_period #(.MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .TMO_CLKS(TMO_CLKS)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .sq      (sq_w),
        .verdict (verd_w)
    );

    cdet_qualify #(.CONFIRM(CONFIRM)) u_qualify (
        .clk     (clk),
        .rst_n   (rst_n),
        .verdict (verd_w),
        .det     (det_w)
    );

    assign cyc_good = (verd_w == VERD_GOOD);
    assign cyc_bad  = (verd_w == VERD_BAD);
    assign sq_out   = sq_w;
    assign det_n    = !det_w;

endmodule

// File: rtl/cdet_chk.sv
module cdet_chk #(
    parameter int unsigned MIN_PER  = 15,
    parameter int unsigned MAX_PER  = 17,
    parameter int unsigned TMO_CLKS = 18
) (
    input logic clk,
    input logic rst_n,
    input logic cmp_hi,
    input logic cmp_lo,
    input logic sq_out,
    input logic det_n,
    input logic cyc_good,
    input logic cyc_bad
);

    localparam int unsigned GAP_W = $clog2(TMO_CLKS + 2) + 1;

    logic [1:0]       age_q;
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic             sq_prev_q;
    logic             sq_rise;

    assign sq_rise = sq_out && !sq_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q     <= '0;
            gap_q     <= '0;
            seen_q    <= 1'b0;
            sq_prev_q <= 1'b1;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            sq_prev_q <= sq_out;
            if (sq_rise) begin
                gap_q  <= GAP_W'(1);
                seen_q <= 1'b1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + GAP_W'(1);
            end
        end
    end

    AST_HI_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && cmp_hi && !cmp_lo && $past(cmp_hi) && !$past(cmp_lo)
         && $past(cmp_hi, 2) && !$past(cmp_lo, 2)) |=> !sq_out); // R2

    AST_LO_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && cmp_lo && !cmp_hi && $past(cmp_lo) && !$past(cmp_hi)
         && $past(cmp_lo, 2) && !$past(cmp_hi, 2)) |=> sq_out); // R2

    AST_NEITHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !cmp_hi && !cmp_lo && !$past(cmp_hi) && !$past(cmp_lo)
         && !$past(cmp_hi, 2) && !$past(cmp_lo, 2)) |=> $stable(sq_out)); // R2

    AST_GOOD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_good |-> (seen_q && sq_rise && gap_q >= GAP_W'(MIN_PER)
                      && gap_q <= GAP_W'(MAX_PER))); // R3

    AST_TIMEOUT_IS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !sq_rise && gap_q == GAP_W'(TMO_CLKS)) |-> cyc_bad); // R5

    AST_DET_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_n) |-> $past(cyc_good)); // R6

    AST_REL_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_n) |-> $past(cyc_bad)); // R7

endmodule

bind carrier_window_det cdet_chk #(
    .MIN_PER  (MIN_PER),
    .MAX_PER  (MAX_PER),
    .TMO_CLKS (TMO_CLKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_hi   (cmp_hi),
    .cmp_lo   (cmp_lo),
    .sq_out   (sq_out),
    .det_n    (det_n),
    .cyc_good (cyc_good),
    .cyc_bad  (cyc_bad)
);

// File: tb/carrier_window_det_tb.sv
module carrier_window_det_tb;

    localparam int C   = 10;
    localparam int TMO = 18;
    localparam int REL = 21 + TMO * (C - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_hi = 1'b0;
    logic cmp_lo = 1'b0;
    logic sq_out;
    logic det_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = !clk;

    carrier_window_det #(.CONFIRM(C), .TMO_CLKS(TMO)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_hi (cmp_hi),
        .cmp_lo (cmp_lo),
        .sq_out (sq_out),
        .det_n  (det_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic hi, input logic lo, input int n);
        cmp_hi = hi;
        cmp_lo = lo;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int per, input int n);
        for (int k = 0; k < n; k++) begin
            drive(1'b0, 1'b1, per / 2);
            drive(1'b1, 1'b0, per - per / 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 det_n in reset", int'(det_n), 1);
        chk("R1 sq_out in reset", int'(sq_out), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 det_n after reset", int'(det_n), 1);

        // R2: hysteresis latch, three-edge latency
        drive(1'b1, 1'b0, 2);
        chk("R2 hi latency edge2", int'(sq_out), 1);
        @(negedge clk);
        chk("R2 hi drives low", int'(sq_out), 0);
        drive(1'b0, 1'b0, 5);
        chk("R2 neither holds low", int'(sq_out), 0);
        drive(1'b1, 1'b1, 5);
        chk("R2 both holds low", int'(sq_out), 0);
        drive(1'b0, 1'b1, 2);
        chk("R2 lo latency edge2", int'(sq_out), 0);
        @(negedge clk);
        chk("R2 lo drives high", int'(sq_out), 1);
        drive(1'b0, 1'b0, 5);
        chk("R2 neither holds high", int'(sq_out), 1);
        drive(1'b1, 1'b1, 5);
        chk("R2 both holds high", int'(sq_out), 1);
        drive(1'b1, 1'b0, 40);

        // R3 R4 R6: sweep of periods, detect exactly on the C+1-th rise
        for (int p = 10; p <= 22; p++) begin
            automatic int inwin = (p >= 15 && p <= 17) ? 1 : 0;
            send(p, C);
            chk("R6 no detect after C rises", int'(det_n), 1);
            send(p, 1);
            chk(inwin ? "R3 in-window period detects" : "R4 out-of-window never detects",
                int'(det_n), inwin ? 0 : 1);
            if (inwin != 0) begin
                drive(1'b1, 1'b0, 300);
                chk("R7 silence releases", int'(det_n), 1);
            end else begin
                drive(1'b1, 1'b0, 40);
            end
        end

        // R7: exact release edge on a silent line
        send(16, C + 1);
        chk("R6 acquire before silence", int'(det_n), 0);
        drive(1'b1, 1'b0, REL - 16);
        chk("R7 held one edge before release", int'(det_n), 0);
        drive(1'b1, 1'b0, 1);
        chk("R7 released on computed edge", int'(det_n), 1);
        drive(1'b1, 1'b0, 40);

        // R7 R4: release by out-of-window periods
        send(16, C + 1);
        chk("R6 acquire", int'(det_n), 0);
        send(12, C);
        chk("R7 held after C-1 bad", int'(det_n), 0);
        send(12, 1);
        chk("R7 released after C bad", int'(det_n), 1);
        drive(1'b1, 1'b0, 40);

        // R8: acquisition interrupted by a short period
        send(16, C - 1);
        send(12, 1);
        send(16, C);
        chk("R8 short period restarts run", int'(det_n), 1);
        send(16, 1);
        chk("R8 detect after full new run", int'(det_n), 0);

        // R8: loss interrupted by a good period
        send(12, C - 1);
        send(16, 2);
        send(12, C);
        chk("R8 good period restarts loss run", int'(det_n), 0);
        send(12, 1);
        chk("R8 release after full new run", int'(det_n), 1);
        drive(1'b1, 1'b0, 40);

        // R5: a missing edge counts as bad and disarms
        send(16, C - 1);
        send(22, 1);
        send(16, C);
        chk("R5 timeout restarts run", int'(det_n), 1);
        send(16, 1);
        chk("R5 detect after re-arm", int'(det_n), 0);

        // R1: reset while detected
        rst_n = 1'b0;
        #1;
        chk("R1 det_n on async reset", int'(det_n), 1);
        chk("R1 sq_out on async reset", int'(sq_out), 1);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 4);
        chk("R1 stays idle after reset", int'(det_n), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule